// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a processor request port and a word-addressed main memory port. Each processor access carries a 16-bit word address, which the controller splits into a tag, a line index and a word offset. It holds 128 lines of 16 words, with one tag, one valid flag and one dirty flag per line, and the data array is inside the block. A hit is answered in the cycle the request is presented. A miss starts a line transfer on the memory port. If the line being replaced holds modified data, that line is first copied back in full. The new block is then read in ascending word order.

Read misses forward the requested word to the processor in the cycle it arrives from memory, and the rest of the line keeps streaming in behind it. Write misses allocate the line first and then complete as an ordinary write hit. Processor writes only touch the cache until the line is evicted. A separate snoop input carries the block number of any main memory block that another agent, such as a DMA engine, has overwritten. If that block is resident, its line is invalidated, so the next access fetches the new contents.

The processor holds `cpu_req` and its operands steady until it sees `cpu_ready`, and drops the request in the following cycle. The memory side holds a request until it is acknowledged, and the acknowledge may take any number of cycles.

Top module: `dm_wb_cache`

## Requirements
- R1: Reset clears every valid and dirty flag and leaves `cpu_ready` and `mem_req` low. No memory request is raised until a processor request has been seen, and the first access to any line after reset is a miss.
- R2: The address field decoding is: tag = bits [15:11], line index = bits [10:4], word offset = bits [3:0]. Block number J (address bits [15:4]) always occupies line J mod 128, so two blocks that differ only in tag evict each other.
- R3: A read that hits raises `cpu_ready` in the cycle of the request, with the most recent data for that address on `cpu_rdata`, and raises no memory request.
- R4: A write that hits updates the cached word, marks the line dirty, raises `cpu_ready` in the cycle of the request and writes nothing to memory.
- R5: A miss on a dirty line first writes all 16 words of the resident block to memory, at offsets 0 to 15 in ascending order, even if only one word was modified. The 16-word read of the new block follows.
- R6: A miss on a clean or invalid line reads the new block without any memory write.
- R7: On a read miss, `cpu_ready` rises in the cycle the requested word is acknowledged by memory, that is, after offset+1 read acknowledges, with that word on `cpu_rdata`. The fill still completes all 16 words.
- R8: A write miss reads the whole block into the line and then writes the word in the cache, with a single `cpu_ready`. It produces no memory write at that time.
- R9: A snoop whose block number matches a resident valid line clears that line's valid flag. The next access to that block misses and returns the new memory contents.
- R10: A snoop for a block that is not resident leaves the cache unchanged, so a following access to the line that is resident still hits.
- R11: A snoop that names the block being fetched takes effect when the fill ends, so the line is left invalid and the next access to it misses.
- R12: `mem_req`, `mem_we` and `mem_addr` stay stable until `mem_ack`. Every line transfer starts at offset 0 and steps up by one per acknowledge.
- R13: Each processor request gets exactly one single-cycle `cpu_ready` pulse. New requests are stalled while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Processor word address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | 1 = write-back word, 0 = fill read |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 16 | Write-back data |
| mem_ack | input | 1 | Memory acknowledge, one cycle per word |
| mem_rdata | input | 16 | Fill data, valid with `mem_ack` |
| snoop_valid | input | 1 | An external agent wrote a main memory block |
| snoop_blk | input | 12 | Block number (address bits [15:4]) of that write |

## Verification
The bench sweeps all 128 lines with read misses, hits, write hits and conflicting tags, and keeps its own copy of memory that it compares against every forwarded word and every written-back block. Several faults produce a visible symptom. A design that waited for the whole line before answering would report too many read acknowledges at `cpu_ready`. A write-through design, or one that skips the copy-back, would show the wrong number of memory writes or stale data in the memory model. A wrongly sliced index would let blocks that should not collide evict each other.

Snoops are aimed at a resident clean line, at a block that is not resident, and at the block being filled. An invalidation that is lost would show up as a hit that returns stale data, and one applied to the wrong line would show up as an unexpected miss. Memory latency varies from word to word, which exposes a controller that moves on without waiting for `mem_ack`.

// File: rtl/cache_pkg.sv
`timescale 1ns/1ps
// Shared types for the direct-mapped cache controller.
// Assumes: nothing beyond the standard.
package cache_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } cache_state_e;
endpackage

// File: rtl/cache_tag_store.sv
`timescale 1ns/1ps
// Tag, valid and dirty storage, one entry per line.
// Provides one lookup port for the controller and one for the snoop.
// Assumes the controller never invalidates and fills the same line in one cycle.
module cache_tag_store #(
    parameter int TAG_W = 5,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic             lk_dirty,
    output logic [TAG_W-1:0] lk_tag_q,
    input  logic [IDX_W-1:0] sn_idx,
    input  logic [TAG_W-1:0] sn_tag,
    output logic             sn_hit,
    input  logic             dirty_set,
    input  logic             inval_en,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_valid
);
    localparam int LINES = 1 << IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Combinational lookups for the controller and the snoop port.
    always_comb begin
        lk_tag_q = tag_q[lk_idx];
        lk_hit   = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_dirty = valid_q[lk_idx] && dirty_q[lk_idx];
        sn_hit   = valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);
    end

    // Valid and dirty flags: cleared on reset, updated by hits, snoops and fills.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (dirty_set) dirty_q[lk_idx] <= 1'b1;
            if (inval_en)  valid_q[sn_idx] <= 1'b0;
            if (fill_en) begin
                valid_q[fill_idx] <= fill_valid;
                dirty_q[fill_idx] <= 1'b0;
            end
        end
    end

    // Tag array: written when a fill completes.
    always_ff @(posedge clk) begin
        if (fill_en) tag_q[fill_idx] <= fill_tag;
    end
endmodule

// File: rtl/cache_data_store.sv
`timescale 1ns/1ps
// Line data array, one write port and one asynchronous read port.
// Assumes the caller muxes the location for hits, fills and write-backs.
module cache_data_store #(
    parameter int DATA_W = 16,
    parameter int LOC_W  = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LOC_W-1:0]  wloc,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LOC_W-1:0]  rloc,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << LOC_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Word write from a processor hit or a fill beat.
    always_ff @(posedge clk) begin
        if (we) mem_q[wloc] <= wdata;
    end

    // Word read for hits and write-back beats.
    assign rdata = mem_q[rloc];
endmodule

// File: rtl/dm_wb_cache.sv
`timescale 1ns/1ps
// Direct-mapped write-back, write-allocate cache controller with read
// forwarding during fills and snoop invalidation.
// Assumes: the processor holds its request until cpu_ready and then drops it;
// memory holds mem_rdata valid with a one-cycle mem_ack per word.
module dm_wb_cache
    import cache_pkg::*;
#(
    parameter int TAG_W  = 5,
    parameter int IDX_W  = 7,
    parameter int OFF_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic                         cpu_ready,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         mem_req,
    output logic                         mem_we,
    output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic                         mem_ack,
    input  logic [DATA_W-1:0]            mem_rdata,
    input  logic                         snoop_valid,
    input  logic [TAG_W+IDX_W-1:0]       snoop_blk
);
    localparam int LOC_W = IDX_W + OFF_W;

    cache_state_e     state;
    logic [TAG_W-1:0] c_tag, s_tag, m_tag, lk_tag_q;
    logic [IDX_W-1:0] c_idx, s_idx, m_idx, lk_idx;
    logic [OFF_W-1:0] c_off, m_off, cnt;
    logic             m_we, snp_pend;
    logic             busy, lk_hit, lk_dirty, sn_hit;
    logic             hit_go, miss_go, fill_ack, word_last, snp_line, snp_blk_hit;
    logic             dw_en;
    logic [LOC_W-1:0] dw_loc, dr_loc;
    logic [DATA_W-1:0] dw_data, rd_word;

    assign {c_tag, c_idx, c_off} = cpu_addr;
    assign {s_tag, s_idx}        = snoop_blk;

    // Request decode and datapath steering.
    always_comb begin
        busy        = (state != ST_IDLE);
        lk_idx      = busy ? m_idx : c_idx;
        hit_go      = (state == ST_IDLE) && cpu_req && lk_hit;
        miss_go     = (state == ST_IDLE) && cpu_req && !lk_hit;
        fill_ack    = (state == ST_FILL) && mem_ack;
        word_last   = (cnt == {OFF_W{1'b1}});
        snp_line    = busy && (s_idx == m_idx);
        snp_blk_hit = snoop_valid && snp_line && (s_tag == m_tag);
        dw_en       = (hit_go && cpu_we) || fill_ack;
        dw_loc      = fill_ack ? {m_idx, cnt} : {c_idx, c_off};
        dw_data     = fill_ack ? mem_rdata : cpu_wdata;
        dr_loc      = busy ? {m_idx, cnt} : {c_idx, c_off};
        mem_req     = busy;
        mem_we      = (state == ST_WBACK);
        mem_addr    = {(mem_we ? lk_tag_q : m_tag), m_idx, cnt};
        mem_wdata   = rd_word;
        cpu_ready   = hit_go || (fill_ack && !m_we && (cnt == m_off));
        cpu_rdata   = busy ? mem_rdata : rd_word;
    end

    cache_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_tag    (c_tag),
        .lk_hit    (lk_hit),
        .lk_dirty  (lk_dirty),
        .lk_tag_q  (lk_tag_q),
        .sn_idx    (s_idx),
        .sn_tag    (s_tag),
        .sn_hit    (sn_hit),
        .dirty_set (hit_go && cpu_we),
        .inval_en  (snoop_valid && sn_hit && !snp_line),
        .fill_en   (fill_ack && word_last),
        .fill_idx  (m_idx),
        .fill_tag  (m_tag),
        .fill_valid(!(snp_pend || snp_blk_hit))
    );

    cache_data_store #(.DATA_W(DATA_W), .LOC_W(LOC_W)) u_data (
        .clk  (clk),
        .we   (dw_en),
        .wloc (dw_loc),
        .wdata(dw_data),
        .rloc (dr_loc),
        .rdata(rd_word)
    );

    // Miss sequencer: optional write-back, then ascending fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            snp_pend <= 1'b0;
            m_tag    <= '0;
            m_idx    <= '0;
            m_off    <= '0;
            m_we     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (miss_go) begin
                        m_tag    <= c_tag;
                        m_idx    <= c_idx;
                        m_off    <= c_off;
                        m_we     <= cpu_we;
                        cnt      <= '0;
                        snp_pend <= 1'b0;
                        state    <= lk_dirty ? ST_WBACK : ST_FILL;
                    end
                end
                ST_WBACK: begin
                    if (snp_blk_hit) snp_pend <= 1'b1;
                    if (mem_ack) begin
                        cnt <= cnt + 1'b1;
                        if (word_last) state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (snp_blk_hit) snp_pend <= 1'b1;
                    if (mem_ack) begin
                        cnt <= cnt + 1'b1;
                        if (word_last) state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cache_sva.sv
`timescale 1ns/1ps
// Protocol checker for dm_wb_cache, attached by bind below.
// Assumes: observes only the ports of the cache.
module cache_sva #(
    parameter int OFF_W  = 4,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_rdata
);
    // R1: memory traffic only ever follows a processor request
    a_r1_no_spontaneous_traffic: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> $past(cpu_req));

    // R12: request fields held until acknowledged
    a_r12_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: beats step upward by one word
    a_r12_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && (mem_addr[OFF_W-1:0] != {OFF_W{1'b1}}))
        |=> (mem_req && (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1))));

    // R5: a finished write-back is followed by a fill from offset 0
    a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ack && mem_we && (mem_addr[OFF_W-1:0] == {OFF_W{1'b1}}))
        |=> (mem_req && !mem_we && (mem_addr[OFF_W-1:0] == '0)));

    // R7: a forwarded word is the fill word of that beat
    a_r7_forward_data: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && mem_ack) |-> (!mem_we && (cpu_rdata == mem_rdata)));

    // R13: a forwarding pulse lasts one cycle
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && mem_ack) |=> !cpu_ready);
endmodule

bind dm_wb_cache cache_sva #(
    .OFF_W (OFF_W),
    .ADDR_W(TAG_W + IDX_W + OFF_W),
    .DATA_W(DATA_W)
) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .mem_rdata(mem_rdata)
);

// File: tb/tb_dm_wb_cache.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every line with a reference memory model.
module tb_dm_wb_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [15:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        snoop_valid = 1'b0;
    logic [11:0] snoop_blk = '0;

    int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0, cyc = 0;
    int wait_cnt = 0, lat_sel = 0, order_err = 0;
    logic [3:0] exp_rd_off = '0, exp_wr_off = '0;
    logic [15:0] mw [int];
    logic [15:0] gw [int];
    int a_nrd, a_nwr, a_pulses, a_at;
    logic [15:0] a_rd;

    always #10 clk = ~clk;   // 50 MHz

    dm_wb_cache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .snoop_valid(snoop_valid), .snoop_blk(snoop_blk)
    );

    function automatic logic [15:0] init_val(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C96;
    endfunction
    function automatic logic [15:0] mm(logic [15:0] a);
        return mw.exists(int'(a)) ? mw[int'(a)] : init_val(a);
    endfunction
    function automatic logic [15:0] gold(logic [15:0] a);
        return gw.exists(int'(a)) ? gw[int'(a)] : init_val(a);
    endfunction
    function automatic logic [15:0] mk(int tag, int idx, int off);
        return {tag[4:0], idx[6:0], off[3:0]};
    endfunction

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Memory model with a latency that changes from beat to beat; also checks beat order.
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack = 1'b0;
            wait_cnt = 0;
        end else if (mem_req) begin
            if (wait_cnt >= (lat_sel % 3)) begin
                mem_ack = 1'b1;
                lat_sel++;
                wait_cnt = 0;
                if (mem_we) begin
                    if (mem_addr[3:0] != exp_wr_off) order_err++;
                    exp_wr_off = mem_addr[3:0] + 4'd1;
                    mw[int'(mem_addr)] = mem_wdata;
                    n_wr++;
                end else begin
                    if (mem_addr[3:0] != exp_rd_off) order_err++;
                    exp_rd_off = mem_addr[3:0] + 4'd1;
                    mem_rdata = mm(mem_addr);
                    n_rd++;
                end
            end else begin
                wait_cnt++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
            finish_up();
        end
    end

    // One processor access; records data, traffic and ready pulses.
    task automatic access(bit we, logic [15:0] addr, logic [15:0] wd);
        int r0 = n_rd;
        int w0 = n_wr;
        a_pulses = 0;
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        forever begin
            #5;
            if (cpu_ready) begin
                a_pulses++;
                a_rd = cpu_rdata;
                a_at = n_rd - r0;
                break;
            end
            @(negedge clk);
        end
        if (we) gw[int'(addr)] = wd;
        @(negedge clk);
        cpu_req = 1'b0;
        while (mem_req) begin
            #5;
            if (cpu_ready) a_pulses++;
            @(negedge clk);
        end
        a_nrd = n_rd - r0;
        a_nwr = n_wr - w0;
    endtask

    task automatic snoop(logic [15:0] addr, logic [15:0] d);
        @(negedge clk);
        mw[int'(addr)] = d;
        gw[int'(addr)] = d;
        snoop_valid = 1'b1;
        snoop_blk = addr[15:4];
        @(negedge clk);
        snoop_valid = 1'b0;
    endtask

    initial begin
        logic [15:0] exp_old;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #5;
        chk("R1 ready low after reset", cpu_ready, 0);
        chk("R1 mem_req low after reset", mem_req, 0);
        repeat (5) @(negedge clk);
        chk("R1 no traffic while idle", n_rd + n_wr, 0);

        // R2/R7/R1: read miss on every line, tag 3, forwarding offset varies
        for (int i = 0; i < 128; i++) begin
            access(1'b0, mk(3, i, i % 16), '0);
            chk("R7 forwarded data", a_rd, gold(mk(3, i, i % 16)));
            chk("R7 ready at requested beat", a_at, (i % 16) + 1);
            chk("R1 first access misses, full fill", a_nrd, 16);
            chk("R6 no write on invalid line", a_nwr, 0);
            chk("R13 one ready pulse", a_pulses, 1);
        end

        // R3: read hits on every line at another offset
        for (int i = 0; i < 128; i++) begin
            access(1'b0, mk(3, i, 15 - (i % 16)), '0);
            chk("R3 hit data", a_rd, gold(mk(3, i, 15 - (i % 16))));
            chk("R3 hit has no traffic", a_nrd + a_nwr, 0);
        end

        // R4: write hits on even lines, then read back
        for (int i = 0; i < 128; i += 2) begin
            access(1'b1, mk(3, i, i % 16), 16'(i * 257) ^ 16'hC0DE);
            chk("R4 write hit no traffic", a_nrd + a_nwr, 0);
            chk("R13 one ready pulse on write", a_pulses, 1);
            access(1'b0, mk(3, i, i % 16), '0);
            chk("R4 readback", a_rd, gold(mk(3, i, i % 16)));
            chk("R4 memory not written", mm(mk(3, i, i % 16)), init_val(mk(3, i, i % 16)));
        end

        // R2/R5/R6: conflicting tag evicts; dirty lines copied back in full
        for (int i = 0; i < 128; i++) begin
            access(1'b0, mk(9, i, 0), '0);
            chk("R2 conflict misses", a_nrd, 16);
            chk("R5/R6 write-back count", a_nwr, (i % 2 == 0) ? 16 : 0);
            chk("R2 new block data", a_rd, gold(mk(9, i, 0)));
            if (i % 2 == 0)
                for (int w = 0; w < 16; w++)
                    chk("R5 written-back word", mm(mk(3, i, w)), gold(mk(3, i, w)));
        end

        // R8: write miss onto a clean line
        access(1'b1, mk(20, 5, 7), 16'hBEEF);
        chk("R8 write miss fills", a_nrd, 16);
        chk("R8 no write-back of clean line", a_nwr, 0);
        chk("R13 write miss single ready", a_pulses, 1);
        access(1'b0, mk(20, 5, 7), '0);
        chk("R8 allocated word reads back", a_rd, 16'hBEEF);
        chk("R8 read after allocate hits", a_nrd, 0);
        chk("R8 memory untouched", mm(mk(20, 5, 7)), init_val(mk(20, 5, 7)));

        // R9: snoop of a resident clean line
        snoop(mk(9, 6, 3), 16'h1234);
        access(1'b0, mk(9, 6, 3), '0);
        chk("R9 invalidated line misses", a_nrd, 16);
        chk("R9 new memory data", a_rd, 16'h1234);

        // R10: snoop of a block that is not resident
        snoop(mk(1, 7, 0), 16'h4321);
        access(1'b0, mk(9, 7, 2), '0);
        chk("R10 resident line still hits", a_nrd, 0);
        chk("R10 data intact", a_rd, gold(mk(9, 7, 2)));

        // R11: snoop of the block being filled
        exp_old = gold(mk(12, 8, 2));
        base = n_rd;
        fork
            access(1'b0, mk(12, 8, 2), '0);
            begin
                wait (n_rd - base >= 5);
                snoop(mk(12, 8, 9), 16'h7777);
            end
        join
        chk("R11 forwarded word during fill", a_rd, exp_old);
        access(1'b0, mk(12, 8, 9), '0);
        chk("R11 line invalid after fill", a_nrd, 16);
        chk("R11 fresh data", a_rd, 16'h7777);

        // R5/R8: write miss onto a dirty line
        access(1'b1, mk(9, 10, 4), 16'hA11A);
        access(1'b1, mk(15, 10, 1), 16'h5EED);
        chk("R5 dirty victim written back", a_nwr, 16);
        chk("R8 fill after write-back", a_nrd, 16);
        chk("R5 victim word in memory", mm(mk(9, 10, 4)), 16'hA11A);
        access(1'b0, mk(15, 10, 1), '0);
        chk("R8 written word after dirty eviction", a_rd, 16'h5EED);

        chk("R12 beats ascending from offset 0", order_err, 0);
        finish_up();
    end
endmodule